// File: doc/BRIEF.md
# ADC Conversion Command Sequencer

This block is the digital controller in front of an analog-to-digital converter. It holds one command byte that selects three things: signed differential or unsigned single-ended operation, a conversion mode, and the source that starts a conversion. It requests each conversion from an abstract converter port through a one-cycle `conv_start` pulse. The converter answers some cycles later with a `conv_done` pulse and a result word. The block either returns that word directly or adds it into an accumulator. The accumulator is used in two ways:
- Series: each trigger adds one sample.
- Burst: one trigger runs a whole back-to-back sequence.

A conversion can be started in four ways: an immediate request, a write strobe on the positive input select, a write strobe on the negative input select, or an external event pulse. The number of samples per sequence is a power of two and comes from the `samp_log2` input. The scaling modes divide the finished sum by the sample count, up to a fixed maximum shift. When a sequence or single conversion ends, `res_valid` pulses for one cycle and `res_data` is updated.

Top module: `adc_cmd_seq`

## Requirements
- R1: The command readback `cmd_rdata` is {diff[7], mode[6:4], 0[3], src[2:0]}. Bit 3 always reads 0. All fields are 0 after reset, and `conv_start` and `res_valid` are low after reset.
- R2: A mode value of 6 or 7 is stored and acts as mode 1 (single 12-bit). A source value of 5, 6 or 7 is stored as 0 (stop) and starts nothing.
- R3: When `enable` is 0, a write of source 1 (immediate) is stored as 0. While `enable` is 0, no source starts a conversion.
- R4: The source codes are: 1 = immediate, 2 = `posmux_we` strobe, 3 = `negmux_we` strobe, 4 = `event_in` pulse. Only the selected source starts a conversion. `conv_start` is a single-cycle pulse in the second cycle after the trigger is sampled.
- R5: A trigger that arrives while a conversion is pending produces no extra `conv_start`.
- R6: Mode 1 returns the converter word as is. Mode 0 returns the word's upper 8 bits. `res_valid` pulses in the cycle after `conv_done`.
- R7: Modes 2 and 3 (series) run exactly one conversion per trigger. The result is produced only after 2^samp_log2 conversions, and in mode 2 it equals their sum.
- R8: Modes 4 and 5 (burst) run 2^samp_log2 conversions from one trigger. Each new `conv_start` comes one cycle after the previous `conv_done`.
- R9: Modes 3 and 5 shift the sum right by min(samp_log2, 4). The shift is arithmetic when differential.
- R10: After an immediate-started conversion completes, the source field reads back 0, unless `free_run` is 1. With `free_run` at 1 the field stays at 1 and conversions repeat.
- R11: Writing source 0 while a conversion is pending abandons it. Its `conv_done` produces no result.
- R12: A command write that changes the mode from an accumulating mode (2 to 5) to a single mode (0 or 1) discards the partial sum and the sample count.
- R13: `conv_diff` follows command bit 7. When it is 1, samples are treated as two's complement, and results are sign-extended to the width of `res_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; gates all start sources |
| free_run | input | 1 | Keeps the immediate source active after completion |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command write data |
| cmd_rdata | output | 8 | Command register readback |
| posmux_we | input | 1 | Positive input select write strobe |
| negmux_we | input | 1 | Negative input select write strobe |
| event_in | input | 1 | External start event |
| samp_log2 | input | 3 | log2 of the samples per sequence (0 to 6) |
| conv_start | output | 1 | Conversion request pulse |
| conv_diff | output | 1 | Differential conversion select |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 12 | Converter result word |
| res_valid | output | 1 | Result update pulse |
| res_data | output | 18 | Result value |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- Reserved mode and source codes: a design that stored them raw would read back the wrong value or start a conversion from a dead source.
- An immediate request written while the block is disabled: a faulty design would start a conversion anyway.
- A trigger during a pending conversion: a faulty design would issue an extra start and skew the series sum.
- Signed burst with the shift capped at 4: an unsigned shift, or a shift by the full log2 count, gives a visibly wrong negative result.
- Abort: a missing abort turns the late done pulse into a stray result.
- Mode change from accumulating to single: a missing clear leaves the old partial sum inside the next series result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      MD_S8   = 3'd0,
      MD_S12  = 3'd1,
      MD_SER  = 3'd2,
      MD_SERS = 3'd3,
      MD_BUR  = 3'd4,
      MD_BURS = 3'd5
   } mode_e;

   typedef enum logic [2:0] {
      SS_STOP = 3'd0,
      SS_IMM  = 3'd1,
      SS_POS  = 3'd2,
      SS_NEG  = 3'd3,
      SS_EVT  = 3'd4
   } src_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } seq_state_e;

   function automatic logic is_accum(mode_e m);
      return (m >= MD_SER) && (m <= MD_BURS);
   endfunction

   function automatic logic is_burst(mode_e m);
      return (m == MD_BUR) || (m == MD_BURS);
   endfunction

   function automatic logic is_scaled(mode_e m);
      return (m == MD_SERS) || (m == MD_BURS);
   endfunction

endpackage

// File: rtl/adc_cmd_reg.sv
module adc_cmd_reg
   import adc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       free_run,
   input  logic       we,
   input  logic [7:0] wdata,
   input  logic       seq_end,
   output logic [7:0] rdata,
   output logic       diff,
   output mode_e      mode,
   output src_e       src,
   output logic       acc_clr
);

   logic  diff_q;
   mode_e mode_q;
   src_e  src_q;
   mode_e w_mode;
   src_e  w_src;

   always_comb begin
      if (wdata[6:4] > 3'd5) w_mode = MD_S12;
      else                   w_mode = mode_e'(wdata[6:4]);
      if (wdata[2:0] > 3'd4)                    w_src = SS_STOP;
      else if (wdata[2:0] == 3'd1 && !enable)  w_src = SS_STOP;
      else                                      w_src = src_e'(wdata[2:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         diff_q <= 1'b0;
         mode_q <= MD_S8;
         src_q  <= SS_STOP;
      end else if (we) begin
         diff_q <= wdata[7];
         mode_q <= w_mode;
         src_q  <= w_src;
      end else if (seq_end && src_q == SS_IMM && !free_run) begin
         src_q  <= SS_STOP;
      end
   end

   assign acc_clr = we && is_accum(mode_q) && !is_accum(w_mode);
   assign diff    = diff_q;
   assign mode    = mode_q;
   assign src     = src_q;
   assign rdata   = {diff_q, mode_q, 1'b0, src_q};

   AST_IMM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[2:0] == 3'd1 && !enable) |=> (src == SS_STOP)); // R3
   AST_RSV_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[6:4] > 3'd5) |=> (mode == MD_S12)); // R2
   AST_RSV_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[2:0] > 3'd4) |=> (src == SS_STOP)); // R2
   AST_BIT3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata[3] == 1'b0)); // R1

endmodule

// File: rtl/adc_trig.sv
module adc_trig
   import adc_seq_pkg::*;
#(
   parameter bit EVT_EDGE = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic idle,
   input  src_e src,
   input  logic posmux_we,
   input  logic negmux_we,
   input  logic event_in,
   output logic fire
);

   logic evt_p;
   logic hit;

   generate
      if (EVT_EDGE) begin : g_evt_edge
         logic evt_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_d <= 1'b0;
            else        evt_d <= event_in;
         end
         assign evt_p = event_in & ~evt_d;
      end else begin : g_evt_pulse
         assign evt_p = event_in;
      end
   endgenerate

   always_comb begin
      case (src)
         SS_IMM:  hit = 1'b1;
         SS_POS:  hit = posmux_we;
         SS_NEG:  hit = negmux_we;
         SS_EVT:  hit = evt_p;
         default: hit = 1'b0;
      endcase
   end

   assign fire = enable & idle & hit;

endmodule

// File: rtl/adc_accum.sv
module adc_accum #(
   parameter int DW = 12,
   parameter int AW = 18
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          add,
   input  logic          sgn,
   input  logic [DW-1:0] din,
   output logic [AW-1:0] sum_o
);

   logic [AW-1:0] acc_q;
   logic [AW-1:0] ext;

   generate
      if (AW < DW) begin : g_bad_aw
         $error("adc_accum: AW must not be below DW");
      end
   endgenerate

   always_comb begin
      if (sgn) ext = {{(AW-DW){din[DW-1]}}, din};
      else     ext = {{(AW-DW){1'b0}}, din};
   end

   assign sum_o = acc_q + ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (add) acc_q <= sum_o;
   end

   AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0)); // R12

endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
   import adc_seq_pkg::*;
#(
   parameter int DW       = 12,
   parameter int MAXL     = 6,
   parameter int SHMAX    = 4,
   parameter bit EVT_EDGE = 1'b0,
   localparam int AW      = DW + MAXL,
   localparam int LW      = $clog2(MAXL + 1),
   localparam int CW      = MAXL + 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          free_run,
   input  logic          cmd_we,
   input  logic [7:0]    cmd_wdata,
   output logic [7:0]    cmd_rdata,
   input  logic          posmux_we,
   input  logic          negmux_we,
   input  logic          event_in,
   input  logic [LW-1:0] samp_log2,
   output logic          conv_start,
   output logic          conv_diff,
   input  logic          conv_done,
   input  logic [DW-1:0] conv_data,
   output logic          res_valid,
   output logic [AW-1:0] res_data
);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("adc_cmd_seq: DW must be at least 8");
      end
      if (SHMAX > MAXL) begin : g_bad_sh
         $error("adc_cmd_seq: SHMAX must not exceed MAXL");
      end
   endgenerate

   logic       diff;
   mode_e      mode;
   src_e       src;
   logic       cmd_clr;
   logic       seq_end;
   logic       fire;
   seq_state_e state_q, state_d;

   logic [CW-1:0] cnt_q;
   logic [LW-1:0] lg;
   logic [LW-1:0] sh_amt;
   logic [CW-1:0] n_target;
   logic          abort;
   logic          took;
   logic          last;
   logic          acc_add;
   logic          acc_clr;
   logic [AW-1:0] sum_w;
   logic [AW-1:0] single_w;
   logic [AW-1:0] scaled_w;
   logic          vld_q;
   logic [AW-1:0] res_q;

   adc_cmd_reg u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .free_run (free_run),
      .we       (cmd_we),
      .wdata    (cmd_wdata),
      .seq_end  (seq_end),
      .rdata    (cmd_rdata),
      .diff     (diff),
      .mode     (mode),
      .src      (src),
      .acc_clr  (cmd_clr)
   );

   adc_trig #(.EVT_EDGE(EVT_EDGE)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .idle      (state_q == ST_IDLE),
      .src       (src),
      .posmux_we (posmux_we),
      .negmux_we (negmux_we),
      .event_in  (event_in),
      .fire      (fire)
   );

   assign lg       = (samp_log2 > LW'(MAXL)) ? LW'(MAXL) : samp_log2;
   assign sh_amt   = is_scaled(mode) ? ((lg > LW'(SHMAX)) ? LW'(SHMAX) : lg) : '0;
   assign n_target = CW'(1) << lg;

   assign abort   = (state_q != ST_IDLE) && (src == SS_STOP);
   assign took    = (state_q == ST_WAIT) && conv_done && !abort;
   assign last    = !is_accum(mode) || ((cnt_q + CW'(1)) == n_target);
   assign acc_add = took && is_accum(mode) && !last;
   assign acc_clr = cmd_clr || (took && is_accum(mode) && last);

   adc_accum #(.DW(DW), .AW(AW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (acc_clr),
      .add   (acc_add),
      .sgn   (diff),
      .din   (conv_data),
      .sum_o (sum_w)
   );

   always_comb begin
      if (mode == MD_S8) begin
         if (diff) single_w = {{(AW-8){conv_data[DW-1]}}, conv_data[DW-1 -: 8]};
         else      single_w = {{(AW-8){1'b0}}, conv_data[DW-1 -: 8]};
      end else begin
         if (diff) single_w = {{(AW-DW){conv_data[DW-1]}}, conv_data};
         else      single_w = {{(AW-DW){1'b0}}, conv_data};
      end
      if (diff) scaled_w = AW'($signed(sum_w) >>> sh_amt);
      else      scaled_w = sum_w >> sh_amt;
   end

   always_comb begin
      state_d = state_q;
      seq_end = 1'b0;
      case (state_q)
         ST_IDLE: if (fire) state_d = ST_REQ;
         ST_REQ:  state_d = abort ? ST_IDLE : ST_WAIT;
         ST_WAIT: begin
            if (abort) begin
               state_d = ST_IDLE;
            end else if (conv_done) begin
               if (is_burst(mode) && !last) begin
                  state_d = ST_REQ;
               end else begin
                  state_d = ST_IDLE;
                  seq_end = 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         vld_q   <= 1'b0;
         res_q   <= '0;
      end else begin
         state_q <= state_d;
         vld_q   <= 1'b0;
         if (cmd_clr) begin
            cnt_q <= '0;
         end else if (acc_add) begin
            cnt_q <= cnt_q + CW'(1);
         end
         if (took && last) begin
            vld_q <= 1'b1;
            res_q <= is_accum(mode) ? scaled_w : single_w;
            cnt_q <= '0;
         end
      end
   end

   assign conv_start = (state_q == ST_REQ);
   assign conv_diff  = diff;
   assign res_valid  = vld_q;
   assign res_data   = res_q;

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start); // R4
   AST_NO_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !conv_done) |=> !conv_start); // R5
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && state_q == ST_IDLE) |=> (state_q == ST_IDLE)); // R3
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SS_STOP && state_q == ST_WAIT && !cmd_we) |=> (state_q == ST_IDLE && !res_valid)); // R11
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R7

endmodule

// File: tb/adc_cmd_seq_tb_top.sv
module adc_cmd_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b1;
   logic        free_run = 1'b0;
   logic        cmd_we = 1'b0;
   logic [7:0]  cmd_wdata = 8'h00;
   logic [7:0]  cmd_rdata;
   logic        posmux_we = 1'b0;
   logic        negmux_we = 1'b0;
   logic        event_in = 1'b0;
   logic [2:0]  samp_log2 = 3'd0;
   logic        conv_start;
   logic        conv_diff;
   logic        conv_done = 1'b0;
   logic [11:0] conv_data = 12'h000;
   logic        res_valid;
   logic [17:0] res_data;

   int checks = 0;
   int errors = 0;
   int n_starts = 0;
   int n_res = 0;
   int cd = 0;
   bit done_flag = 1'b0;

   logic [11:0] samp_q[$];
   logic [17:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   adc_cmd_seq dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .free_run(free_run),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
      .posmux_we(posmux_we), .negmux_we(negmux_we), .event_in(event_in),
      .samp_log2(samp_log2), .conv_start(conv_start), .conv_diff(conv_diff),
      .conv_done(conv_done), .conv_data(conv_data),
      .res_valid(res_valid), .res_data(res_data)
   );

   // converter model: done three cycles after a start is seen
   always @(posedge clk) begin
      conv_done <= 1'b0;
      if (cd > 0) begin
         cd <= cd - 1;
         if (cd == 1) begin
            conv_done <= 1'b1;
            conv_data <= (samp_q.size() > 0) ? samp_q.pop_front() : 12'h000;
         end
      end
      if (conv_start) cd <= 3;
   end

   // monitor: pop expected results and compare
   always @(negedge clk) begin
      if (conv_start) n_starts++;
      if (rst_n && res_valid) begin
         n_res++;
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected result: actual %h expected none", res_data);
         end else begin
            automatic logic [17:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (res_data !== e) begin
               errors++;
               $display("FAIL %s result: actual %h expected %h", t, res_data, e);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic expect_res(input logic [17:0] v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic wr_cmd(input logic [7:0] v);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic pulse_pos();
      @(negedge clk); posmux_we = 1'b1; @(negedge clk); posmux_we = 1'b0;
   endtask
   task automatic pulse_neg();
      @(negedge clk); negmux_we = 1'b1; @(negedge clk); negmux_we = 1'b0;
   endtask
   task automatic pulse_evt();
      @(negedge clk); event_in = 1'b1; @(negedge clk); event_in = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_res(input int target);
      for (int i = 0; i < 3000 && n_res < target; i++) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      int s;
      int sum;
      logic [11:0] v;

      idle(3);
      chk("R1 reset cmd", {24'd0, cmd_rdata}, 32'h00);
      chk("R1 reset start", {31'd0, conv_start}, 32'd0);
      chk("R1 reset valid", {31'd0, res_valid}, 32'd0);
      rst_n = 1'b1;
      idle(2);

      wr_cmd(8'hDC);
      chk("R1 field layout", {24'd0, cmd_rdata}, 32'hD4);
      chk("R13 conv_diff", {31'd0, conv_diff}, 32'd1);
      wr_cmd(8'h76);
      chk("R2 reserved codes", {24'd0, cmd_rdata}, 32'h10);
      base = n_starts;
      idle(10);
      chk("R2 reserved source idle", n_starts - base, 0);

      enable = 1'b0;
      wr_cmd(8'h11);
      chk("R3 imm while disabled", {24'd0, cmd_rdata}, 32'h10);
      wr_cmd(8'h14);
      pulse_evt();
      idle(10);
      chk("R3 no start when disabled", n_starts - base, 0);
      enable = 1'b1;

      // single 12-bit, immediate
      samp_q.push_back(12'hABC);
      expect_res(18'h00ABC, "R6");
      base = n_starts;
      wr_cmd(8'h11);
      wait_res(1);
      chk("R10 imm self clear", {24'd0, cmd_rdata}, 32'h10);
      chk("R4 one start", n_starts - base, 1);

      // single 8-bit differential on event; other strobes ignored
      wr_cmd(8'h84);
      chk("R13 diff output", {31'd0, conv_diff}, 32'd1);
      base = n_starts;
      pulse_pos();
      pulse_neg();
      idle(8);
      chk("R4 unselected sources", n_starts - base, 0);
      samp_q.push_back(12'h9A5);
      expect_res(18'h3FF9A, "R6 R13");
      pulse_evt();
      wait_res(2);

      // series with scaling, positive-select strobe, N=4 shift 2
      samp_log2 = 3'd2;
      wr_cmd(8'h32);
      base = n_starts;
      samp_q.push_back(12'd100); samp_q.push_back(12'd200);
      samp_q.push_back(12'd300); samp_q.push_back(12'd401);
      expect_res(18'd250, "R7 R9");
      pulse_pos();
      pulse_pos();
      idle(8);
      chk("R5 busy trigger ignored", n_starts - base, 1);
      chk("R7 no early result", n_res, 2);
      repeat (3) begin
         pulse_pos();
         idle(8);
      end
      wait_res(3);
      chk("R7 series starts", n_starts - base, 4);

      // burst unsigned, negative-select strobe, N=8
      samp_log2 = 3'd3;
      wr_cmd(8'h43);
      base = n_starts;
      for (int i = 0; i < 8; i++) samp_q.push_back(12'hFFF);
      expect_res(18'd32760, "R8");
      pulse_neg();
      wait_res(4);
      chk("R8 burst starts", n_starts - base, 8);

      // burst differential with scaling, N=32, shift capped at 4
      samp_log2 = 3'd5;
      wr_cmd(8'hD4);
      sum = 0;
      for (int i = 0; i < 32; i++) begin
         v = 12'((i * 293 + 1000) % 4096);
         samp_q.push_back(v);
         s = (v >= 12'd2048) ? (int'(v) - 4096) : int'(v);
         sum += s;
      end
      expect_res(18'(sum >>> 4), "R9 R13");
      pulse_evt();
      wait_res(5);

      // mode change from series to single discards the partial sum
      samp_log2 = 3'd1;
      wr_cmd(8'h24);
      samp_q.push_back(12'd50);
      pulse_evt();
      idle(8);
      wr_cmd(8'h14);
      wr_cmd(8'h24);
      samp_q.push_back(12'd7); samp_q.push_back(12'd8);
      expect_res(18'd15, "R12");
      pulse_evt(); idle(8);
      pulse_evt();
      wait_res(6);

      // free-running immediate
      free_run = 1'b1;
      for (int i = 0; i < 3; i++) begin
         samp_q.push_back(12'(i + 17));
         expect_res(18'(i + 17), "R10 free run");
      end
      wr_cmd(8'h11);
      wait_res(7);
      chk("R10 field stays", {24'd0, cmd_rdata}, 32'h11);
      wait_res(9);
      wr_cmd(8'h10);
      idle(6);
      base = n_starts;
      idle(20);
      chk("R10 stop halts", n_starts - base, 0);
      free_run = 1'b0;
      samp_q.delete();

      // abort a pending conversion
      wr_cmd(8'h14);
      samp_q.push_back(12'h123);
      pulse_evt();
      wr_cmd(8'h10);
      idle(12);
      chk("R11 no result after abort", n_res, 9);
      chk("R11 expected queue empty", exp_q.size(), 0);

      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule